// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating

This block serialises bytes onto an asynchronous line. Software pushes bytes into a 16-entry queue. Whenever the line is idle, the queue holds data and the clear-to-send input is asserted (active low), the block takes the oldest byte. It then sends one character: a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. Every bit lasts sixteen pulses of an external oversampling strobe, so the strobe rate sets the baud rate.

Three format inputs choose the data width (seven or eight bits), whether a parity bit is added, and the number of stop bits. The format is captured at the moment a character starts. A change made mid-character therefore only affects the next one. The clear-to-send input is looked at only between characters, so a character already on the line always finishes. The queue occupancy and an empty flag are visible to software. A push into a full queue is discarded and raises a sticky overflow flag.

Top module: `uart_tx_cts`

## Requirements
- R1: After reset, txd is 1, fifo_empty is 1, fifo_count is 0 and overflow is 0, and txd stays 1 whenever no character is being sent.
- R2: A character is a 0 start bit, then the data bits least significant bit first, then the optional parity bit, then the stop bits (1). Each bit lasts 16 strobe pulses.
- R3: With fmt_seven = 1, only wdata[6:0] is sent (7 data bits). With fmt_seven = 0, all 8 bits of wdata are sent.
- R4: With fmt_parity = 1, one parity bit follows the data bits. It is chosen so that the count of ones in the data bits plus the parity bit is even. With fmt_parity = 0, no parity bit is sent.
- R5: fmt_two_stop = 0 sends one stop bit, and fmt_two_stop = 1 sends two.
- R6: The queue holds up to 16 bytes and sends them in push order. fifo_count gives the number of stored bytes, and fifo_empty is 1 exactly when that number is 0.
- R7: A push while fifo_count is 16 is discarded: the byte is never sent and the count is unchanged. It also sets overflow, which stays 1 until reset.
- R8: A new character starts only while cts_n is 0 and the queue is not empty. Raising cts_n during a character does not shorten that character. While cts_n is 1, nothing further is sent and the queue keeps its contents.
- R9: The three format inputs are captured when a character starts. Changing them during a character alters only later characters.
- R10: Bit timing counts strobe pulses, not clock cycles. While a character is in progress and tick16 is 0, txd does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling strobe, sixteen pulses per bit |
| push | input | 1 | Write wdata into the queue |
| wdata | input | 8 | Byte to queue |
| fmt_seven | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| fmt_parity | input | 1 | 1 adds an even parity bit |
| fmt_two_stop | input | 1 | 1 selects two stop bits |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial line, idles high |
| fifo_empty | output | 1 | Queue holds no bytes |
| fifo_count | output | 5 | Number of bytes in the queue |
| overflow | output | 1 | Sticky flag for a discarded push |

## Verification
The bench decodes every character at the line by sampling at mid-bit. It compares the result with a frame built from the format in force when the character began. This catches a design that mixes up data width, parity sense or stop count, or that lets a mid-character format change leak into the current frame. It fills the queue past its limit with flow control off, then drains it. A design that overwrote the oldest entry, or accepted the seventeenth byte, would show the wrong sequence or an extra character. Finally, clear-to-send is dropped in the middle of a character and the strobe is slowed to one pulse every three clocks. A design that cut frames short, ignored flow control or timed bits in clock cycles would then put a visibly wrong or early edge on txd.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int FRAME_W = 12;

  typedef struct packed {
    logic seven;
    logic par_en;
    logic two_stop;
  } fmt_t;

  // bit count of a whole character: start + data + parity + stop
  function automatic logic [3:0] frame_len(fmt_t f);
    frame_len = 4'd10 - {3'b0, f.seven} + {3'b0, f.par_en} + {3'b0, f.two_stop};
  endfunction

  // even parity over the data bits that go on the line
  function automatic logic even_par(logic [7:0] d, logic seven);
    even_par = seven ? ^d[6:0] : ^d;
  endfunction

  // line image, bit 0 first; unused upper positions are stop level
  function automatic logic [FRAME_W-1:0] build_frame(logic [7:0] d, fmt_t f);
    logic [FRAME_W-1:0] v;
    v    = '1;
    v[0] = 1'b0;
    if (f.seven) begin
      v[7:1] = d[6:0];
      v[8]   = f.par_en ? even_par(d, 1'b1) : 1'b1;
    end else begin
      v[8:1] = d;
      v[9]   = f.par_en ? even_par(d, 1'b0) : 1'b1;
    end
    build_frame = v;
  endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          drop
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_ok, rd_ok;

  function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] p);
    next_ptr = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // fullness is judged on the registered count, so a pop in the
  // same cycle does not make room for a push
  assign wr_ok = push && (count != CW'(DEPTH));
  assign rd_ok = pop && (count != '0);
  assign drop  = push && !wr_ok;
  assign empty = (count == '0);
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= next_ptr(wr_ptr);
      if (rd_ok) rd_ptr <= next_ptr(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_bittimer.sv
module uart_tx_bittimer #(
  parameter int OVS = 16,
  localparam int SW = $clog2(OVS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic bit_end
);

  logic [SW-1:0] sub;

  assign bit_end = run && tick && (sub == SW'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sub <= '0;
    else if (!run)   sub <= '0;
    else if (tick)   sub <= (sub == SW'(OVS - 1)) ? '0 : sub + 1'b1;
  end

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_ok,
  input  logic [7:0] data,
  input  fmt_t       fmt,
  input  logic       bit_end,
  output logic       take,
  output logic       busy,
  output logic       txd
);

  logic [FRAME_W-1:0] sreg;
  logic [3:0]         left;

  assign take = !busy && start_ok;
  assign txd  = busy ? sreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sreg <= '1;
      left <= '0;
    end else if (take) begin
      busy <= 1'b1;
      sreg <= build_frame(data, fmt);
      left <= frame_len(fmt);
    end else if (busy && bit_end) begin
      sreg <= {1'b1, sreg[FRAME_W-1:1]};
      left <= left - 1'b1;
      if (left == 4'd1) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          push,
  input  logic [7:0]    wdata,
  input  logic          fmt_seven,
  input  logic          fmt_parity,
  input  logic          fmt_two_stop,
  input  logic          cts_n,
  output logic          txd,
  output logic          fifo_empty,
  output logic [CW-1:0] fifo_count,
  output logic          overflow
);

  logic       char_start;
  logic       busy;
  logic       bit_end;
  logic       push_drop;
  logic [7:0] head;
  fmt_t       fmt;

  assign fmt = '{seven: fmt_seven, par_en: fmt_parity, two_stop: fmt_two_stop};

  uart_tx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (wdata),
    .pop   (char_start),
    .rdata (head),
    .count (fifo_count),
    .empty (fifo_empty),
    .drop  (push_drop)
  );

  uart_tx_bittimer #(.OVS(OVS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .tick    (tick16),
    .bit_end (bit_end)
  );

  uart_tx_serializer u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ok (!fifo_empty && !cts_n),
    .data     (head),
    .fmt      (fmt),
    .bit_end  (bit_end),
    .take     (char_start),
    .busy     (busy),
    .txd      (txd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overflow <= 1'b0;
    else if (push_drop) overflow <= 1'b1;
  end

endmodule

// File: rtl/uart_tx_cts_chk.sv
module uart_tx_cts_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick16,
  input logic          push,
  input logic          cts_n,
  input logic          txd,
  input logic          fifo_empty,
  input logic [CW-1:0] fifo_count,
  input logic          overflow,
  input logic          busy,
  input logic          char_start
);

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    char_start |=> !txd);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  a_r7_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (push && fifo_count == CW'(DEPTH)) |=> overflow);

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r8_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    char_start |-> (!cts_n && !fifo_empty && !busy));

  a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick16) |=> $stable(txd));

endmodule

bind uart_tx_cts uart_tx_cts_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick16     (tick16),
  .push       (push),
  .cts_n      (cts_n),
  .txd        (txd),
  .fifo_empty (fifo_empty),
  .fifo_count (fifo_count),
  .overflow   (overflow),
  .busy       (busy),
  .char_start (char_start)
);

// File: tb/sim_uart_tx_cts.sv
`timescale 1ns/100ps
module sim_uart_tx_cts;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       push = 1'b0;
  logic [7:0] wdata = '0;
  logic       fmt_seven = 1'b0, fmt_parity = 1'b0, fmt_two_stop = 1'b0;
  logic       cts_n = 1'b1;
  logic       txd, fifo_empty, overflow;
  logic [4:0] fifo_count;

  int n_total = 0, n_fail = 0;
  int tick_div = 1;
  logic nxt_seven, nxt_parity, nxt_two;

  uart_tx_cts u0 (.*);

  always #2.5 clk = ~clk;

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      tick16 = (cnt == 0);
      cnt = (cnt + 1 >= tick_div) ? 0 : cnt + 1;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_push(input logic [7:0] d);
    @(negedge clk); push = 1'b1; wdata = d;
    @(negedge clk); push = 1'b0;
  endtask

  task automatic set_fmt(input logic s7, input logic pe, input logic ts);
    fmt_seven = s7; fmt_parity = pe; fmt_two_stop = ts;
  endtask

  // action 1: raise cts_n after the start bit; action 2: load nxt_* format
  task automatic check_frame(input logic [7:0] d, input logic s7, input logic pe,
                             input logic ts, input int action, input string req);
    logic [11:0] exp_v, act_v;
    int nb, k, t;
    logic p;
    exp_v = '0; act_v = '0; k = 1; p = 1'b0;
    for (int i = 0; i < (s7 ? 7 : 8); i++) begin
      exp_v[k] = d[i]; p = p ^ d[i]; k++;
    end
    if (pe) begin exp_v[k] = p; k++; end
    exp_v[k] = 1'b1; k++;
    if (ts) begin exp_v[k] = 1'b1; k++; end
    nb = k;
    t = 0;
    while (txd !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
    if (t >= 4000) begin
      chk(1'b0, req, "no start bit", 0, 1);
      return;
    end
    repeat (8 * tick_div) @(negedge clk);
    act_v[0] = txd;
    if (action == 1) cts_n = 1'b1;
    if (action == 2) set_fmt(nxt_seven, nxt_parity, nxt_two);
    for (int i = 1; i < nb; i++) begin
      repeat (16 * tick_div) @(negedge clk);
      act_v[i] = txd;
    end
    chk(act_v == exp_v, req, "frame", int'(act_v), int'(exp_v));
  endtask

  task automatic quiet_line(input int cycles, input string req);
    bit low = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) low = 1;
    end
    chk(!low, req, "line stayed idle", int'(low), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(txd === 1'b1, "R1", "txd", txd, 1);
    chk(fifo_empty === 1'b1, "R1", "fifo_empty", fifo_empty, 1);
    chk(fifo_count === 5'd0, "R1", "fifo_count", fifo_count, 0);
    chk(overflow === 1'b0, "R1", "overflow", overflow, 0);
  endtask

  task automatic t_basic();
    set_fmt(0, 0, 0); cts_n = 1'b0;
    do_push(8'hA5);
    check_frame(8'hA5, 0, 0, 0, 0, "R2");
    repeat (20) @(negedge clk);
    chk(fifo_empty === 1'b1, "R6", "empty after send", fifo_empty, 1);
    quiet_line(30, "R1");
  endtask

  task automatic t_formats();
    for (int f = 0; f < 8; f++) begin
      logic [7:0] d;
      d = 8'hC3 ^ 8'(f * 37);
      set_fmt(f[2], f[1], f[0]);
      do_push(d);
      check_frame(d, f[2], f[1], f[0], 0, f[1] ? "R4" : (f[2] ? "R3" : "R5"));
      repeat (20) @(negedge clk);
    end
  endtask

  task automatic t_order();
    set_fmt(0, 1, 0); cts_n = 1'b1;
    for (int i = 0; i < 5; i++) do_push(8'(8'h10 + i * 9));
    chk(fifo_count === 5'd5, "R6", "count after 5 pushes", fifo_count, 5);
    chk(fifo_empty === 1'b0, "R6", "not empty", fifo_empty, 0);
    quiet_line(40, "R8");
    cts_n = 1'b0;
    for (int i = 0; i < 5; i++) check_frame(8'(8'h10 + i * 9), 0, 1, 0, 0, "R6");
  endtask

  task automatic t_overflow();
    set_fmt(0, 0, 0); cts_n = 1'b1;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 17; i++) do_push(8'(8'h40 + i));
    chk(fifo_count === 5'd16, "R7", "count at full", fifo_count, 16);
    chk(overflow === 1'b1, "R7", "overflow set", overflow, 1);
    cts_n = 1'b0;
    for (int i = 0; i < 16; i++) check_frame(8'(8'h40 + i), 0, 0, 0, 0, "R7");
    quiet_line(300, "R7");
    chk(fifo_empty === 1'b1, "R7", "drained", fifo_empty, 1);
    chk(overflow === 1'b1, "R7", "overflow sticky", overflow, 1);
  endtask

  task automatic t_cts();
    set_fmt(0, 0, 1); cts_n = 1'b0;
    do_push(8'h5E); do_push(8'h81);
    check_frame(8'h5E, 0, 0, 1, 1, "R8");
    quiet_line(200, "R8");
    chk(fifo_count === 5'd1, "R8", "held byte", fifo_count, 1);
    cts_n = 1'b0;
    check_frame(8'h81, 0, 0, 1, 0, "R8");
    repeat (20) @(negedge clk);
  endtask

  task automatic t_cfg_change();
    set_fmt(0, 0, 0); cts_n = 1'b0;
    nxt_seven = 1'b1; nxt_parity = 1'b1; nxt_two = 1'b1;
    do_push(8'hF0); do_push(8'h3B);
    check_frame(8'hF0, 0, 0, 0, 2, "R9");
    check_frame(8'h3B, 1, 1, 1, 0, "R9");
    repeat (20) @(negedge clk);
  endtask

  task automatic t_slow_tick();
    tick_div = 3;
    set_fmt(0, 1, 1); cts_n = 1'b0;
    do_push(8'h96);
    check_frame(8'h96, 0, 1, 1, 0, "R10");
    repeat (60) @(negedge clk);
    tick_div = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_formats();
    t_order();
    t_cts();
    t_cfg_change();
    t_slow_tick();
    t_overflow();
    summary();
    $finish;
  end

endmodule